// File: doc/BRIEF.md
# Capture/Compare Timer Channel with DMA Request

This block is one 32-bit timer channel. A counter runs from one of three tick sources: every system clock, every sixteenth system clock, or rising edges of an external timer pin. The pin is synchronized into the system clock domain, so the whole channel stays in one clock domain. The count is compared against a reference word. Edges on the same pin can copy the running count into a capture register. Each step adds either 1 or a value that advances the upper and lower 16-bit halves together.

Match and capture events set sticky flags. Each flag can be enabled and then routed to a level interrupt or to a DMA request. A DMA request holds until an acknowledge pulse arrives, and that pulse also clears the flag that caused it. A timer output pin either pulses or toggles on each reference match. Software reaches everything through a small word-wide register port with a 3-bit local offset.

Top module: `cct_timer`

## Requirements
- R1: After reset, the counter, capture register, event register, mode register and the outputs `tout`, `irq` and `dma_req` are zero, and the reference register reads all ones.
- R2: Mode bits [1:0] pick the tick source. 0 stops the counter. 1 ticks every system clock. 2 ticks every 16th system clock, with the divider restarting whenever the counter is cleared. 3 ticks three system clocks after each rising edge of `tin`, which passes through a two-flop synchronizer.
- R3: Mode bit 2 sets the step per tick: 1 when clear, 0x00010001 when set. Arithmetic wraps modulo 2^32.
- R4: A write to offset 3 clears the counter whatever the data, and the clear takes priority over a tick in the same cycle. Reading offset 3 returns the count and never disturbs it.
- R5: The match flag (event bit 1) sets on the tick that makes the count equal to the reference at offset 1. With mode bit 3 set, the next tick loads zero. With mode bit 3 clear, counting continues.
- R6: Mode bits [6:5] pick the capture edge of `tin`: 0 none, 1 rising, 2 falling, 3 both. A selected edge copies the count, as it stood before the third system clock edge after the pin change, into offset 2. It also sets capture flag event bit 0. Edges that are not selected have no effect.
- R7: The event register at offset 4 holds sticky flags. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: Mode bit 7 enables the match flag and bit 9 enables the capture flag. Bit 8 sends the match flag to `dma_req` instead of `irq`, and bit 10 does the same for the capture flag. Each output is the OR of the enabled flags routed to it.
- R9: `dma_req` stays high until `dma_ack` is pulsed. The pulse clears every flag routed to DMA.
- R10: When mode bit 4 is clear, `tout` is high for exactly the system clock in which a new match appears. When bit 4 is set, `tout` inverts on each match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Local register offset (0 mode, 1 reference, 2 capture, 3 count, 4 event) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tin | input | 1 | External timer pin: tick source and capture source |
| tout | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt level |
| dma_req | output | 1 | DMA request level |
| dma_ack | input | 1 | DMA acknowledge pulse |

## Verification
The hardest state to reach is a wrap of the widened step. A wrap carries the lower half into an upper half that is already rolling over. No port can load the counter, so the bench clears it and then runs 65,536 widened ticks, expecting exactly 0x00010000. The capture timing is also awkward because the pin passes through the synchronizer. The bench changes `tin` right after a known clear and sweeps the cycle offsets, so the captured value is fixed arithmetically.

// File: rtl/cct_pkg.sv
package cct_pkg;

   typedef enum logic [1:0] {
      SRC_OFF = 2'd0,
      SRC_SYS = 2'd1,
      SRC_DIV = 2'd2,
      SRC_PIN = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      CAP_NONE = 2'd0,
      CAP_RISE = 2'd1,
      CAP_FALL = 2'd2,
      CAP_BOTH = 2'd3
   } cap_e;

   localparam int MODE_W = 11;

   typedef struct packed {
      logic cap_dma;
      logic cap_en;
      logic match_dma;
      logic match_en;
      cap_e cap_edge;
      logic out_toggle;
      logic restart;
      logic wide_step;
      src_e src;
   } mode_t;

   localparam logic [2:0] OFS_MODE  = 3'd0;
   localparam logic [2:0] OFS_REF   = 3'd1;
   localparam logic [2:0] OFS_CAPT  = 3'd2;
   localparam logic [2:0] OFS_COUNT = 3'd3;
   localparam logic [2:0] OFS_EVENT = 3'd4;

   localparam int EVT_N     = 2;
   localparam int EVT_CAP   = 0;
   localparam int EVT_MATCH = 1;

endpackage

// File: rtl/cct_pin_sync.sv
module cct_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cct_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sq;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[0] <= 1'b0;
            else        sq[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[i] <= 1'b0;
            else        sq[i] <= sq[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sq[STAGES-1];
   end

   assign rise = sq[STAGES-1] & ~prev_q;
   assign fall = ~sq[STAGES-1] & prev_q;
endmodule

// File: rtl/cct_tick_gen.sv
module cct_tick_gen
   import cct_pkg::*;
#(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  src_e src,
   input  logic pin_rise,
   input  logic clr,
   output logic tick
);
   if (DIV < 2) begin : g_bad_div
      $error("cct_tick_gen: DIV must be at least 2");
   end

   localparam int PW = $clog2(DIV);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] pre_q;
   logic          pre_end;

   assign pre_end = (pre_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pre_q <= '0;
      else if (clr || src != SRC_DIV)   pre_q <= '0;
      else if (pre_end)                 pre_q <= '0;
      else                              pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      unique case (src)
         SRC_SYS: tick = 1'b1;
         SRC_DIV: tick = pre_end;
         SRC_PIN: tick = pin_rise;
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/cct_count_core.sv
module cct_count_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   input  logic         wide,
   input  logic         restart,
   input  logic [W-1:0] ref_val,
   output logic [W-1:0] count,
   output logic         match_evt
);
   localparam int HW = W / 2;
   localparam logic [W-1:0] STEP_ONE  = W'(1);
   localparam logic [W-1:0] STEP_WIDE = {{(HW-1){1'b0}}, 1'b1, {(HW-1){1'b0}}, 1'b1};

   logic [W-1:0] count_q;
   logic [W-1:0] step;
   logic [W-1:0] nxt;
   logic         wrap;

   assign step = wide ? STEP_WIDE : STEP_ONE;
   assign wrap = restart && (count_q == ref_val);
   assign nxt  = wrap ? '0 : count_q + step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (clr)  count_q <= '0;
      else if (tick) count_q <= nxt;
   end

   assign match_evt = tick && !clr && (nxt == ref_val);
   assign count     = count_q;
endmodule

// File: rtl/cct_timer.sv
module cct_timer
   import cct_pkg::*;
#(
   parameter int W     = 32,
   parameter int DIV   = 16,
   parameter int SYNC  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [2:0]   addr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   input  logic         tin,
   output logic         tout,
   output logic         irq,
   output logic         dma_req,
   input  logic         dma_ack
);
   if (W < 16 || (W % 2) != 0 || W < MODE_W) begin : g_bad_width
      $error("cct_timer: W must be even and at least 16");
   end

   logic [MODE_W-1:0] mode_q;
   mode_t             mode;
   logic [W-1:0]      ref_q;
   logic [W-1:0]      capt_q;
   logic [EVT_N-1:0]  flag_q;
   logic              tout_q;

   logic wr_mode, wr_ref, clr, wr_evt;
   logic pin_rise, pin_fall;
   logic tick;
   logic [W-1:0] cnt;
   logic match_evt, cap_evt;
   logic [EVT_N-1:0] evt_set, evt_en, evt_dma;

   assign mode    = mode_t'(mode_q);
   assign wr_mode = wr_en && (addr == OFS_MODE);
   assign wr_ref  = wr_en && (addr == OFS_REF);
   assign clr     = wr_en && (addr == OFS_COUNT);
   assign wr_evt  = wr_en && (addr == OFS_EVENT);

   cct_pin_sync #(.STAGES(SYNC)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (tin),
      .rise (pin_rise),
      .fall (pin_fall)
   );

   cct_tick_gen #(.DIV(DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (mode.src),
      .pin_rise(pin_rise),
      .clr     (clr),
      .tick    (tick)
   );

   cct_count_core #(.W(W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .clr      (clr),
      .wide     (mode.wide_step),
      .restart  (mode.restart),
      .ref_val  (ref_q),
      .count    (cnt),
      .match_evt(match_evt)
   );

   always_comb begin
      unique case (mode.cap_edge)
         CAP_RISE: cap_evt = pin_rise;
         CAP_FALL: cap_evt = pin_fall;
         CAP_BOTH: cap_evt = pin_rise | pin_fall;
         default:  cap_evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '1;
         capt_q <= '0;
      end else begin
         if (wr_mode) mode_q <= wdata[MODE_W-1:0];
         if (wr_ref)  ref_q  <= wdata;
         if (cap_evt) capt_q <= cnt;
      end
   end

   assign evt_set[EVT_CAP]   = cap_evt;
   assign evt_set[EVT_MATCH] = match_evt;
   assign evt_en[EVT_CAP]    = mode.cap_en;
   assign evt_en[EVT_MATCH]  = mode.match_en;
   assign evt_dma[EVT_CAP]   = mode.cap_dma;
   assign evt_dma[EVT_MATCH] = mode.match_dma;

   for (genvar i = 0; i < EVT_N; i++) begin : g_flag
      logic drop;
      assign drop = (wr_evt && wdata[i]) || (dma_ack && evt_dma[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q[i] <= 1'b0;
         else if (evt_set[i]) flag_q[i] <= 1'b1;
         else if (drop)       flag_q[i] <= 1'b0;
      end
   end

   assign irq     = |(flag_q & evt_en & ~evt_dma);
   assign dma_req = |(flag_q & evt_en & evt_dma);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tout_q <= 1'b0;
      else if (mode.out_toggle) tout_q <= tout_q ^ match_evt;
      else                      tout_q <= match_evt;
   end
   assign tout = tout_q;

   always_comb begin
      unique case (addr)
         OFS_MODE:  rdata = {{(W-MODE_W){1'b0}}, mode_q};
         OFS_REF:   rdata = ref_q;
         OFS_CAPT:  rdata = capt_q;
         OFS_COUNT: rdata = cnt;
         OFS_EVENT: rdata = {{(W-EVT_N){1'b0}}, flag_q};
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [2:0]   addr,
   input logic         dma_ack,
   input logic         dma_req,
   input logic         tick,
   input logic         wide,
   input logic         restart,
   input logic [W-1:0] ref_val,
   input logic [W-1:0] count,
   input logic [W-1:0] capture,
   input logic         cap_evt,
   input logic         match_evt
);
   localparam int HW = W / 2;
   localparam logic [W-1:0] ONE_W  = W'(1);
   localparam logic [W-1:0] WIDE_W = {{(HW-1){1'b0}}, 1'b1, {(HW-1){1'b0}}, 1'b1};

   logic clr;
   assign clr = wr_en && (addr == 3'd3);

   // R3: a tick without clear or restart adds the selected step
   p_step_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !clr && !(restart && count == ref_val)
      |=> count == $past(count) + ($past(wide) ? WIDE_W : ONE_W));

   // R2: no tick and no clear leaves the count alone
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !clr |=> $stable(count));

   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);

   p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !clr && restart && count == ref_val |=> count == '0);

   p_capture_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> capture == $past(count));

   p_dma_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !dma_ack && !wr_en |=> dma_req);

   p_dma_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ack && !wr_en && !cap_evt && !match_evt |=> !dma_req);
endmodule

bind cct_timer cct_timer_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .dma_ack  (dma_ack),
   .dma_req  (dma_req),
   .tick     (tick),
   .wide     (mode.wide_step),
   .restart  (mode.restart),
   .ref_val  (ref_q),
   .count    (cnt),
   .capture  (capt_q),
   .cap_evt  (cap_evt),
   .match_evt(match_evt)
);

// File: tb/cct_timer_bench.sv
`timescale 1ns/1ps
module cct_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tin = 1'b0;
   logic        tout, irq, dma_req;
   logic        dma_ack = 1'b0;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cct_timer u_cct_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tin(tin), .tout(tout), .irq(irq), .dma_req(dma_req),
      .dma_ack(dma_ack)
   );

   // mode word: src[1:0] wide[2] restart[3] toggle[4] cap_edge[6:5]
   // match_en[7] match_dma[8] cap_en[9] cap_dma[10]
   function automatic logic [31:0] md(int src, bit wide, bit rs, bit tog, int ce,
                                      bit men, bit mdma, bit cen, bit cdma);
      return 32'(src & 3) | (32'(wide) << 2) | (32'(rs) << 3) | (32'(tog) << 4)
           | (32'(ce & 3) << 5) | (32'(men) << 7) | (32'(mdma) << 8)
           | (32'(cen) << 9) | (32'(cdma) << 10);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // stop, clear, drop flags, load reference, then start: count is 0 on return
   task automatic setup(input logic [31:0] m, input logic [31:0] r);
      wr(3'd0, m & ~32'h3);
      wr(3'd3, 32'h0);
      wr(3'd4, 32'h3);
      wr(3'd1, r);
      wr(3'd0, m);
   endtask

   task automatic ack();
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(3'd0, v); chk("R1 mode", v, 32'h0);
      rd(3'd1, v); chk("R1 ref", v, 32'hFFFF_FFFF);
      rd(3'd2, v); chk("R1 capture", v, 32'h0);
      rd(3'd3, v); chk("R1 count", v, 32'h0);
      rd(3'd4, v); chk("R1 event", v, 32'h0);
      chk("R1 outputs", {29'd0, tout, irq, dma_req}, 32'h0);

      // R2 stopped source
      setup(md(0,0,0,0,0,0,0,0,0), 32'hFFFF_FFFF);
      repeat (10) @(negedge clk);
      rd(3'd3, v); chk("R2 stopped", v, 32'h0);

      // R2 and R4: sys/1, read every cycle does not disturb
      setup(md(1,0,0,0,0,0,0,0,0), 32'hFFFF_FFFF);
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         rd(3'd3, v); chk("R2/R4 sys count", v, 32'(k));
      end
      // R4 clear with arbitrary data
      wr(3'd3, 32'hDEAD_BEEF);
      rd(3'd3, v); chk("R4 clear", v, 32'h0);
      repeat (4) @(negedge clk);
      rd(3'd3, v); chk("R4 after clear", v, 32'd4);

      // R2 divide by 16
      setup(md(2,0,0,0,0,0,0,0,0), 32'hFFFF_FFFF);
      repeat (47) @(negedge clk);
      rd(3'd3, v); chk("R2 div16 47", v, 32'd2);
      @(negedge clk);
      rd(3'd3, v); chk("R2 div16 48", v, 32'd3);

      // R3 wide step and wrap
      setup(md(1,1,0,0,0,0,0,0,0), 32'hFFFF_FFFF);
      repeat (3) @(negedge clk);
      rd(3'd3, v); chk("R3 wide 3", v, 32'h0003_0003);
      repeat (65533) @(negedge clk);
      rd(3'd3, v); chk("R3 wide wrap", v, 32'h0001_0000);

      // R5/R8 match without restart, interrupt route
      setup(md(1,0,0,0,0,1,0,0,0), 32'd10);
      repeat (9) @(negedge clk);
      rd(3'd4, v); chk("R5 before match", v, 32'h0);
      chk("R8 irq before", {31'd0, irq}, 32'h0);
      @(negedge clk);
      rd(3'd4, v); chk("R5 match flag", v, 32'h2);
      chk("R8 irq", {31'd0, irq}, 32'h1);
      chk("R8 no dma", {31'd0, dma_req}, 32'h0);
      repeat (2) @(negedge clk);
      rd(3'd3, v); chk("R5 keeps counting", v, 32'd12);
      // R7 W1C: writing 0 keeps, writing 1 clears
      wr(3'd0, md(0,0,0,0,0,1,0,0,0));
      wr(3'd4, 32'h1);
      rd(3'd4, v); chk("R7 write0 keeps", v, 32'h2);
      wr(3'd4, 32'h2);
      rd(3'd4, v); chk("R7 write1 clears", v, 32'h0);
      chk("R7 irq low", {31'd0, irq}, 32'h0);

      // R5 restart sweep, R9 DMA routing
      setup(md(1,0,1,0,0,1,1,0,0), 32'd5);
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         rd(3'd3, v); chk("R5 restart seq", v, 32'(k % 6));
         chk("R9 dma level", {31'd0, dma_req}, (k >= 5) ? 32'h1 : 32'h0);
         chk("R8 irq stays low", {31'd0, irq}, 32'h0);
      end
      wr(3'd0, md(0,0,1,0,0,1,1,0,0));
      repeat (3) @(negedge clk);
      chk("R9 held without ack", {31'd0, dma_req}, 32'h1);
      ack();
      chk("R9 ack drops", {31'd0, dma_req}, 32'h0);
      rd(3'd4, v); chk("R9 ack clears flag", v, 32'h0);

      // R10 pulse mode then toggle mode, period 4
      setup(md(1,0,1,0,0,0,0,0,0), 32'd3);
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         chk("R10 pulse", {31'd0, tout}, ((k % 4) == 3) ? 32'h1 : 32'h0);
      end
      setup(md(1,0,1,1,0,0,0,0,0), 32'd3);
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         chk("R10 toggle", {31'd0, tout}, 32'(((k + 1) / 4) % 2));
      end

      // R6 rising capture to DMA
      setup(md(1,0,0,0,1,0,0,1,1), 32'hFFFF_FFFF);
      tin = 1'b1;
      repeat (2) @(negedge clk);
      rd(3'd4, v); chk("R6 not yet", v, 32'h0);
      @(negedge clk);
      rd(3'd2, v); chk("R6 rise capture", v, 32'd2);
      rd(3'd4, v); chk("R6 cap flag", v, 32'h1);
      chk("R8 cap dma", {31'd0, dma_req}, 32'h1);
      wr(3'd0, md(0,0,0,0,1,0,0,1,1));
      tin = 1'b0;
      repeat (5) @(negedge clk);
      rd(3'd2, v); chk("R6 fall ignored", v, 32'd2);
      ack();
      rd(3'd4, v); chk("R9 ack cap", v, 32'h0);

      // R6 falling only, interrupt route
      setup(md(1,0,0,0,2,0,0,1,0), 32'hFFFF_FFFF);
      tin = 1'b1;
      repeat (6) @(negedge clk);
      rd(3'd4, v); chk("R6 rise ignored", v, 32'h0);
      rd(3'd2, v); chk("R6 rise ignored cap", v, 32'd2);
      tin = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R6 fall capture", v, 32'd8);
      chk("R8 cap irq", {31'd0, irq}, 32'h1);

      // R6 both edges
      setup(md(1,0,0,0,3,0,0,0,0), 32'hFFFF_FFFF);
      tin = 1'b1;
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R6 both rise", v, 32'd2);
      repeat (7) @(negedge clk);
      tin = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R6 both fall", v, 32'd12);

      // R2 external pin clock, pulses 3 high / 3 low (slower than 1/5 clk)
      setup(md(3,0,0,0,0,0,0,0,0), 32'hFFFF_FFFF);
      for (int i = 0; i < 7; i++) begin
         tin = 1'b1;
         if (i == 0) begin
            repeat (2) @(negedge clk);
            rd(3'd3, v); chk("R2 pin latency", v, 32'd0);
            @(negedge clk);
            rd(3'd3, v); chk("R2 pin first", v, 32'd1);
         end else begin
            repeat (3) @(negedge clk);
         end
         tin = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      rd(3'd3, v); chk("R2 pin count", v, 32'd7);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule